// File: doc/BRIEF.md
# GPIO Port with Blink and Per-Group Interrupts

This block is a word-wide general-purpose I/O port. Software reaches it through eight word-addressed registers. Those registers set each pin's direction and output level, and optionally make an output pin flash from one divider shared by all pins. Each input is brought into the clock domain, can be inverted, and can be watched for events. The event can be a rising edge that latches until software clears it, or a level that is followed directly.

Pending events are collected per group of pins. Each group drives one active-high interrupt line. A falling edge or a low level is detected by setting the pin's invert bit, so the detector itself only ever looks for a high value or a rising transition.

Top module: `gpio_blink_port`

## Requirements
- R1: After reset every pin is an input (pinOe all zero, direction register all ones). The output-value, blink, invert, cause, edge-mask and level-mask registers are all zero, and every irq line is low.
- R2: Word address map: 0 output value, 1 direction, 2 blink enable, 3 input invert, 4 input value (read only; writes have no effect), 5 cause, 6 edge mask, 7 level mask. Bit n of each register belongs to pin n. rdData shows the register addressed in one cycle after the next rising clock edge.
- R3: A direction bit of 1 makes the pin an input (pinOe low). A direction bit of 0 makes it drive (pinOe high). A pin that is not blinking drives its output-value bit on pinOut.
- R4: A pin whose blink bit is set drives its output-value bit XOR a shared square wave of period 2^BLINK_LOG2 cycles, so it changes every 2^(BLINK_LOG2-1) cycles. Pins that are not blinking stay steady.
- R5: Each input passes through two flops and is then XORed with its invert bit. The result is what the input-value register reads.
- R6: A pin with its edge-mask bit set (and its level-mask bit clear) sets its cause bit on a 0-to-1 change of the adjusted input. The bit then stays set after the input falls.
- R7: Writing the cause register clears every bit written as 0 and leaves every bit written as 1 unchanged.
- R8: A pin with its level-mask bit set has a cause bit that follows its adjusted input. A clear written while the level is still high is overridden on the next cycle.
- R9: Setting the invert bit turns the edge detector into a falling-edge detector and the level detector into a low-level detector.
- R10: irq[g] is high exactly when some pin in group g has its cause bit set together with its edge-mask or level-mask bit. A pin with neither mask bit set never gains a cause bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register word address for write and read |
| wrEn | input | 1 | Single-cycle write strobe |
| wrData | input | NUM_PINS | Write data |
| rdData | output | NUM_PINS | Registered read data |
| pinIn | input | NUM_PINS | Asynchronous pin input levels |
| pinOut | output | NUM_PINS | Pin output levels |
| pinOe | output | NUM_PINS | Pin drive enables, high drives |
| irq | output | NUM_PINS/GROUP_PINS | Active-high interrupt per pin group |

## Verification
The bench builds the port with 32 pins in four groups of eight and a blink exponent of 4. With the exponent at 4, the blink square wave flips every 8 cycles, so the bench can measure a full half period of the divider rather than just trusting the counter. The full 32-pin, four-group layout puts edge, level, inverted and unmasked pins in different groups. Each group's irq line can then be checked separately, and a line that leaks into a neighbouring group shows up.

// File: rtl/gpio_blink_pkg.sv
package gpio_blink_pkg;

  typedef enum logic [2:0] {
    REG_DOUT  = 3'd0,
    REG_DIR   = 3'd1,
    REG_BLINK = 3'd2,
    REG_INV   = 3'd3,
    REG_DIN   = 3'd4,
    REG_CAUSE = 3'd5,
    REG_EDGE  = 3'd6,
    REG_LEVEL = 3'd7
  } regSel_e;

  typedef struct packed {
    logic wrDout;
    logic wrDir;
    logic wrBlink;
    logic wrInv;
    logic wrCause;
    logic wrEdge;
    logic wrLevel;
    logic blinkPhase;
  } ctrlStrobe_t;

endpackage

// File: rtl/gpio_blink_ctrl.sv
module gpio_blink_ctrl
  import gpio_blink_pkg::*;
#(
  parameter int BLINK_LOG2 = 24
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [2:0]  addr,
  output ctrlStrobe_t strobe
);

  logic [BLINK_LOG2-1:0] divCnt;

  always_ff @(posedge clk) begin
    if (!rstN) divCnt <= '0;
    else       divCnt <= divCnt + 1'b1;
  end

  always_comb begin
    strobe = '0;
    strobe.blinkPhase = divCnt[BLINK_LOG2-1];
    if (wrEn) begin
      unique case (regSel_e'(addr))
        REG_DOUT:  strobe.wrDout  = 1'b1;
        REG_DIR:   strobe.wrDir   = 1'b1;
        REG_BLINK: strobe.wrBlink = 1'b1;
        REG_INV:   strobe.wrInv   = 1'b1;
        REG_CAUSE: strobe.wrCause = 1'b1;
        REG_EDGE:  strobe.wrEdge  = 1'b1;
        REG_LEVEL: strobe.wrLevel = 1'b1;
        default: ;
      endcase
    end
  end

  AST_ONE_WRITE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobe.wrDout, strobe.wrDir, strobe.wrBlink, strobe.wrInv,
                strobe.wrCause, strobe.wrEdge, strobe.wrLevel}) <= 1); // R2

  AST_PHASE_NOT_FAST: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(strobe.blinkPhase) |=> $stable(strobe.blinkPhase)); // R4

endmodule

// File: rtl/gpio_blink_datapath.sv
module gpio_blink_datapath
  import gpio_blink_pkg::*;
#(
  parameter int NUM_PINS   = 32,
  parameter int GROUP_PINS = 8,
  localparam int NUM_GROUPS = NUM_PINS / GROUP_PINS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobe,
  input  logic [2:0]            addr,
  input  logic [NUM_PINS-1:0]   wrData,
  input  logic [NUM_PINS-1:0]   pinIn,
  output logic [NUM_PINS-1:0]   rdData,
  output logic [NUM_PINS-1:0]   pinOut,
  output logic [NUM_PINS-1:0]   pinOe,
  output logic [NUM_GROUPS-1:0] irq
);

  logic [NUM_PINS-1:0] dataOut, dirCtl, blinkEn, invEn, cause, edgeMask, levelMask;
  logic [NUM_PINS-1:0] syncA, syncB, adjIn, adjPrev;
  logic [NUM_PINS-1:0] causeKept, riseHit, causeNext, armed;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOut   <= '0;
      dirCtl    <= '1;
      blinkEn   <= '0;
      invEn     <= '0;
      edgeMask  <= '0;
      levelMask <= '0;
    end else begin
      if (strobe.wrDout)  dataOut   <= wrData;
      if (strobe.wrDir)   dirCtl    <= wrData;
      if (strobe.wrBlink) blinkEn   <= wrData;
      if (strobe.wrInv)   invEn     <= wrData;
      if (strobe.wrEdge)  edgeMask  <= wrData;
      if (strobe.wrLevel) levelMask <= wrData;
    end
  end

  // input capture: two-flop synchronizer then polarity
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA   <= '0;
      syncB   <= '0;
      adjPrev <= '0;
    end else begin
      syncA   <= pinIn;
      syncB   <= syncA;
      adjPrev <= adjIn;
    end
  end

  assign adjIn = syncB ^ invEn;

  // event detection
  always_comb begin
    causeKept = strobe.wrCause ? (cause & wrData) : cause;
    riseHit   = edgeMask & adjIn & ~adjPrev;
    causeNext = (levelMask & adjIn) | (~levelMask & (causeKept | riseHit));
  end

  always_ff @(posedge clk) begin
    if (!rstN) cause <= '0;
    else       cause <= causeNext;
  end

  assign armed = cause & (edgeMask | levelMask);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gen_group
    assign irq[g] = |armed[g*GROUP_PINS +: GROUP_PINS];
  end

  // pin drive
  assign pinOe  = ~dirCtl;
  assign pinOut = dataOut ^ (blinkEn & {NUM_PINS{strobe.blinkPhase}});

  // registered read port
  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else begin
      unique case (regSel_e'(addr))
        REG_DOUT:  rdData <= dataOut;
        REG_DIR:   rdData <= dirCtl;
        REG_BLINK: rdData <= blinkEn;
        REG_INV:   rdData <= invEn;
        REG_DIN:   rdData <= adjIn;
        REG_CAUSE: rdData <= cause;
        REG_EDGE:  rdData <= edgeMask;
        REG_LEVEL: rdData <= levelMask;
        default:   rdData <= '0;
      endcase
    end
  end

  // cycles since reset, used to window the synchronizer check
  logic [1:0] warmCnt;
  always_ff @(posedge clk) begin
    if (!rstN)              warmCnt <= '0;
    else if (warmCnt != 2'd2) warmCnt <= warmCnt + 1'b1;
  end

  AST_SYNC_TWO_STAGES: assert property (@(posedge clk) disable iff (!rstN)
    (warmCnt == 2'd2) |-> (syncB == $past(pinIn, 2))); // R5

  AST_LEVEL_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    (cause & $past(levelMask)) == ($past(adjIn) & $past(levelMask))); // R8

  AST_NO_CAUSE_WHEN_UNMASKED: assert property (@(posedge clk) disable iff (!rstN)
    ((cause & ~$past(cause)) & ~$past(edgeMask | levelMask)) == '0); // R10

  AST_CAUSE_DROPS_ONLY_ON_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (($past(cause) & ~$past(levelMask) & ~cause) &
     ~($past(strobe.wrCause) ? ~$past(wrData) : '0)) == '0); // R7

  AST_STEADY_WITHOUT_BLINK: assert property (@(posedge clk) disable iff (!rstN)
    ((pinOut ^ $past(pinOut)) & ~blinkEn & ~$past(blinkEn) &
     ~(dataOut ^ $past(dataOut))) == '0); // R4

endmodule

// File: rtl/gpio_blink_port.sv
module gpio_blink_port
  import gpio_blink_pkg::*;
#(
  parameter int NUM_PINS   = 32,
  parameter int GROUP_PINS = 8,
  parameter int BLINK_LOG2 = 24,
  localparam int NUM_GROUPS = NUM_PINS / GROUP_PINS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [2:0]            addr,
  input  logic                  wrEn,
  input  logic [NUM_PINS-1:0]   wrData,
  output logic [NUM_PINS-1:0]   rdData,
  input  logic [NUM_PINS-1:0]   pinIn,
  output logic [NUM_PINS-1:0]   pinOut,
  output logic [NUM_PINS-1:0]   pinOe,
  output logic [NUM_GROUPS-1:0] irq
);

  ctrlStrobe_t strobe;

  gpio_blink_ctrl #(.BLINK_LOG2(BLINK_LOG2)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .strobe(strobe)
  );

  gpio_blink_datapath #(.NUM_PINS(NUM_PINS), .GROUP_PINS(GROUP_PINS)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addr(addr), .wrData(wrData),
    .pinIn(pinIn), .rdData(rdData), .pinOut(pinOut), .pinOe(pinOe), .irq(irq)
  );

endmodule

// File: tb/gpio_blink_port_tb_top.sv
`timescale 1ns/1ps
module gpio_blink_port_tb_top;

  localparam int NP = 32;
  localparam int GP = 8;
  localparam int BL = 4;
  localparam int NG = NP / GP;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] addr = '0;
  logic wrEn = 1'b0;
  logic [NP-1:0] wrData = '0;
  logic [NP-1:0] rdData;
  logic [NP-1:0] pinIn = '0;
  logic [NP-1:0] pinOut;
  logic [NP-1:0] pinOe;
  logic [NG-1:0] irq;

  gpio_blink_port #(.NUM_PINS(NP), .GROUP_PINS(GP), .BLINK_LOG2(BL)) dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .irq(irq)
  );

  always #10 clk = ~clk;

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;
  bit finished = 1'b0;

  logic [NP-1:0] expQ[$];
  string         tagQ[$];
  int            dueQ[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares read results when they are due
  always @(negedge clk) begin
    if (dueQ.size() > 0 && dueQ[0] == cyc) begin
      chk(tagQ[0], rdData, expQ[0]);
      void'(dueQ.pop_front());
      void'(tagQ.pop_front());
      void'(expQ.pop_front());
    end
  end

  task automatic regWrite(input logic [2:0] a, input logic [NP-1:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, input logic [NP-1:0] exp, input string tag);
    @(negedge clk);
    addr = a;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    dueQ.push_back(cyc + 1);
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=running expected=done");
    finish();
  end

  initial begin
    int gap;
    logic prevBit;
    waitCyc(4);
    rstN = 1'b1;
    waitCyc(1);

    // R1 reset state
    chk("R1 pinOe", pinOe, '0);
    chk("R1 pinOut", pinOut, '0);
    chk("R1 irq", {{(NP-NG){1'b0}}, irq}, '0);
    regRead(3'd0, '0, "R1 dout");
    regRead(3'd1, '1, "R1 dir");
    regRead(3'd2, '0, "R1 blink");
    regRead(3'd3, '0, "R1 inv");
    regRead(3'd5, '0, "R1 cause");
    regRead(3'd6, '0, "R1 edge");
    regRead(3'd7, '0, "R1 level");

    // R3 direction and drive
    regWrite(3'd1, 32'hFFFF_00FF);
    regWrite(3'd0, 32'h0000_A500);
    chk("R3 pinOe", pinOe, 32'h0000_FF00);
    chk("R3 pinOut", pinOut, 32'h0000_A500);
    regRead(3'd0, 32'h0000_A500, "R2 dout readback");
    regRead(3'd1, 32'hFFFF_00FF, "R2 dir readback");

    // R5 input value, R2 read-only input register
    pinIn = 32'h1234_5678;
    waitCyc(3);
    regRead(3'd4, 32'h1234_5678, "R5 din");
    regWrite(3'd4, 32'hFFFF_FFFF);
    regRead(3'd4, 32'h1234_5678, "R2 din write ignored");
    regWrite(3'd3, 32'h0000_00FF);
    regRead(3'd4, 32'h1234_5687, "R5 din inverted");
    regRead(3'd3, 32'h0000_00FF, "R2 inv readback");
    regWrite(3'd3, 32'h0);

    // R6 rising edge, sticky
    pinIn = '0;
    waitCyc(3);
    regWrite(3'd6, 32'h0000_0001);
    pinIn[0] = 1'b1;
    waitCyc(4);
    regRead(3'd5, 32'h0000_0001, "R6 edge sets cause");
    waitCyc(1);
    chk("R10 irq group0", {{(NP-NG){1'b0}}, irq}, 32'h1);
    pinIn[0] = 1'b0;
    waitCyc(4);
    regRead(3'd5, 32'h0000_0001, "R6 cause sticky");

    // R7 write-zero-to-clear
    regWrite(3'd5, 32'hFFFF_FFFF);
    regRead(3'd5, 32'h0000_0001, "R7 write one keeps");
    regWrite(3'd5, 32'hFFFF_FFFE);
    regRead(3'd5, 32'h0, "R7 write zero clears");
    waitCyc(1);
    chk("R7 irq after clear", {{(NP-NG){1'b0}}, irq}, 32'h0);

    // R10 unmasked pin and mask removal
    pinIn[16] = 1'b1;
    waitCyc(4);
    regRead(3'd5, 32'h0, "R10 unmasked pin no cause");
    waitCyc(1);
    chk("R10 unmasked irq", {{(NP-NG){1'b0}}, irq}, 32'h0);
    pinIn[0] = 1'b1;
    waitCyc(4);
    chk("R10 edge irq", {{(NP-NG){1'b0}}, irq}, 32'h1);
    regWrite(3'd6, 32'h0);
    chk("R10 mask removed irq", {{(NP-NG){1'b0}}, irq}, 32'h0);
    regRead(3'd5, 32'h0000_0001, "R10 cause kept unmasked");
    regWrite(3'd5, 32'h0);

    // R8 level follow
    regWrite(3'd7, 32'h0100_0000);
    pinIn[24] = 1'b1;
    waitCyc(4);
    regRead(3'd5, 32'h0100_0000, "R8 level sets cause");
    waitCyc(1);
    chk("R8 irq group3", {{(NP-NG){1'b0}}, irq}, 32'h8);
    regWrite(3'd5, 32'hFEFF_FFFF);
    regRead(3'd5, 32'h0100_0000, "R8 clear overridden");
    pinIn[24] = 1'b0;
    waitCyc(4);
    regRead(3'd5, 32'h0, "R8 level drop clears");
    waitCyc(1);
    chk("R8 irq drop", {{(NP-NG){1'b0}}, irq}, 32'h0);
    regWrite(3'd7, 32'h0);

    // R9 falling edge and low level through inversion
    pinIn[17] = 1'b1;
    pinIn[26] = 1'b0;
    waitCyc(3);
    regWrite(3'd3, 32'h0402_0000);
    regWrite(3'd6, 32'h0002_0000);
    regWrite(3'd7, 32'h0400_0000);
    pinIn[17] = 1'b0;
    waitCyc(4);
    regRead(3'd5, 32'h0402_0000, "R9 falling edge and low level");
    waitCyc(1);
    chk("R9 irq groups", {{(NP-NG){1'b0}}, irq}, 32'hC);
    regWrite(3'd7, 32'h0);
    regWrite(3'd6, 32'h0);
    regWrite(3'd5, 32'h0);

    // R4 blink half period
    regWrite(3'd2, 32'h0000_0100);
    prevBit = pinOut[8];
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pinOut[8] != prevBit) break;
    end
    prevBit = pinOut[8];
    gap = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      gap++;
      chk("R4 steady pin10", {31'b0, pinOut[10]}, 32'h1);
      if (pinOut[8] != prevBit) break;
    end
    chk("R4 blink half period", gap, 1 << (BL - 1));

    while (dueQ.size() > 0) @(negedge clk);
    finish();
  end

endmodule